// File: doc/BRIEF.md
# Periodic Timebase Interrupt Generator

This block divides an oscillator-domain clock with a free-running 22-bit counter and raises a sticky flag each time a selected power-of-two period elapses. A 3-bit rate code picks one of eight tap points, and a prescale bit stretches every period by a factor of 128. Software sees a single 8-bit control/status register. That register holds the run enable, the interrupt enable, the rate code, the prescale bit, a write-one acknowledge and the read-only flag. The interrupt request is the flag gated by the interrupt enable.

The block follows the device's low-power states. In wait mode it keeps counting. In stop mode it keeps counting only when the stop-clock-enable strap is high; otherwise the count freezes until stop ends. In either low-power state the register cannot be reached from the bus. While in stop, a pending interrupt drives a wakeup request, so the block can bring the device out of stop at a fixed interval.

Top module: `periodic_tick_irq`

## Requirements
- R1: After reset, every register field is 0, `bus_rdata` reads 0x00, and `irq` and `wakeup` are low.
- R2: Register layout: bit 0 run, bit 1 interrupt enable, bits 4:2 rate code, bit 5 prescale, bit 6 acknowledge (write-only, reads 0), bit 7 flag (read-only). With prescale 0, rate codes 0 to 7 give periods of 32768, 8192, 2048, 128, 64, 32, 16 and 8 clocks. Counting starts at the clock edge that sets run. The flag is first visible exactly one period of clocks after that edge.
- R3: With prescale 1, each period is 128 times the prescale-0 value (codes 0 to 7: 4194304, 1048576, 262144, 16384, 8192, 4096, 2048, 1024 clocks).
- R4: While run is 0 the counter is held at zero and no flag is raised. Setting run again restarts a full, exact period.
- R5: While run reads 1, writes to the rate code and prescale bits are ignored. Run and interrupt enable stay writable.
- R6: The flag stays set until a write with bit 6 set clears it. `irq` equals flag AND interrupt enable.
- R7: If a period ends on the same edge as an acknowledge write, the flag remains set.
- R8: While `wait_mode` or `stop_mode` is high, bus writes change no register field and `bus_rdata` reads 0x00. Counting continues in wait mode, and the flag can still set.
- R9: In stop mode with `stop_clk_en` low, the counter freezes. The period in progress is lengthened by exactly the number of stopped clocks.
- R10: In stop mode with `stop_clk_en` high, counting continues. `wakeup` is high exactly while `stop_mode` and `irq` are both high.
- R11: The counter is free-running, so flags recur every period without reloading, independent of when the acknowledge was written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-domain clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Register read data, zero in low-power states |
| wait_mode | input | 1 | Device is in wait mode |
| stop_mode | input | 1 | Device is in stop mode |
| stop_clk_en | input | 1 | Strap: counter keeps its clock in stop mode |
| irq | output | 1 | Interrupt request (flag AND enable) |
| wakeup | output | 1 | Request to leave stop mode |

## Verification
A wrong tap selection or a counter that fails to clear shows up as a first flag that arrives a period too early or too late. The bench therefore times the first `irq` to the exact clock after the run edge, for every prescale-0 code and several prescale-1 codes. A counter that keeps running or freezes in the wrong power state moves the next flag by the number of stop or wait clocks, and this is visible within one short period. Register corruption through the bus during low power, a lost acknowledge or a race between acknowledge and period end appears at the next read-back or on `irq` within one cycle.

// File: rtl/tbi_pkg.sv
package tbi_pkg;

    localparam int unsigned RATE_W = 3;
    localparam int unsigned REG_W  = 8;

    // register bit positions
    localparam int unsigned B_RUN  = 0;
    localparam int unsigned B_IE   = 1;
    localparam int unsigned B_RATE = 2;
    localparam int unsigned B_PSCL = 5;
    localparam int unsigned B_ACK  = 6;
    localparam int unsigned B_FLAG = 7;

    typedef struct packed {
        logic              run;
        logic              ie;
        logic [RATE_W-1:0] rate;
        logic              pscl;
        logic              flag;
    } ctl_t;

    // counter bit index whose carry marks the end of a period
    function automatic int unsigned tap_exp(input logic [RATE_W-1:0] code,
                                            input logic              pscl,
                                            input int unsigned       shift,
                                            input int unsigned       limit);
        int unsigned e;
        case (code)
            3'd0:    e = 15;
            3'd1:    e = 13;
            3'd2:    e = 11;
            3'd3:    e = 7;
            3'd4:    e = 6;
            3'd5:    e = 5;
            3'd6:    e = 4;
            default: e = 3;
        endcase
        if (pscl) e = e + shift;
        if (e > limit) e = limit;
        return e;
    endfunction

endpackage

// File: rtl/tbi_counter.sv
module tbi_counter
    import tbi_pkg::*;
#(
    parameter int unsigned CNT_W      = 22,
    parameter int unsigned PSCL_SHIFT = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run_i,
    input  logic              adv_i,
    input  logic [RATE_W-1:0] rate_i,
    input  logic              pscl_i,
    output logic              tick_o
);
    localparam int unsigned EXP_W = $clog2(CNT_W + 1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W:0]   ones_below;
    logic [EXP_W-1:0] tap;

    assign ones_below[0] = 1'b1;
    for (genvar i = 0; i < CNT_W; i++) begin : g_carry
        assign ones_below[i+1] = ones_below[i] & cnt_q[i];
    end

    assign tap    = EXP_W'(tap_exp(rate_i, pscl_i, PSCL_SHIFT, CNT_W));
    assign tick_o = adv_i && ones_below[tap];

    always_comb begin
        cnt_d = cnt_q;
        if (!run_i)
            cnt_d = '0;
        else if (adv_i)
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assert_hold_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> (cnt_q == '0));

    assert_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && !adv_i) |=> $stable(cnt_q));

    assert_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && adv_i) |=> (cnt_q != $past(cnt_q)));

endmodule

// File: rtl/tbi_regs.sv
module tbi_regs
    import tbi_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [REG_W-1:0]  wdata_i,
    input  logic              lp_i,
    input  logic              tick_i,
    output logic [REG_W-1:0]  rdata_o,
    output logic              run_o,
    output logic              ie_o,
    output logic [RATE_W-1:0] rate_o,
    output logic              pscl_o,
    output logic              flag_o
);
    ctl_t ctl_q, ctl_d;
    logic wr_ok;
    logic ack_req;
    logic unused_wbit;

    assign wr_ok       = sel_i && wr_i && !lp_i;
    assign ack_req     = wr_ok && wdata_i[B_ACK];
    assign unused_wbit = wdata_i[B_FLAG];

    always_comb begin
        ctl_d = ctl_q;
        if (wr_ok) begin
            ctl_d.run = wdata_i[B_RUN];
            ctl_d.ie  = wdata_i[B_IE];
            if (!ctl_q.run) begin
                ctl_d.rate = wdata_i[B_RATE +: RATE_W];
                ctl_d.pscl = wdata_i[B_PSCL];
            end
        end
        if (tick_i)
            ctl_d.flag = 1'b1;
        else if (ack_req)
            ctl_d.flag = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        rdata_o = '0;
        if (!lp_i) begin
            rdata_o[B_RUN]              = ctl_q.run;
            rdata_o[B_IE]               = ctl_q.ie;
            rdata_o[B_RATE +: RATE_W]   = ctl_q.rate;
            rdata_o[B_PSCL]             = ctl_q.pscl;
            rdata_o[B_FLAG]             = ctl_q.flag;
        end
    end

    assign run_o  = ctl_q.run;
    assign ie_o   = ctl_q.ie;
    assign rate_o = ctl_q.rate;
    assign pscl_o = ctl_q.pscl;
    assign flag_o = ctl_q.flag;

    assert_rate_locked_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.run |=> $stable({ctl_q.rate, ctl_q.pscl}));

    assert_flag_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.flag && !ack_req) |=> ctl_q.flag);

    assert_tick_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> ctl_q.flag);

    assert_lp_no_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
        lp_i |=> $stable({ctl_q.run, ctl_q.ie, ctl_q.rate, ctl_q.pscl}));

endmodule

// File: rtl/tbi_lowpower.sv
module tbi_lowpower (
    input  logic run_i,
    input  logic wait_i,
    input  logic stop_i,
    input  logic stop_clk_en_i,
    input  logic irq_i,
    output logic adv_o,
    output logic lp_o,
    output logic wakeup_o
);
    logic clk_gated;

    assign clk_gated = stop_i && !stop_clk_en_i;
    assign adv_o     = run_i && !clk_gated;
    assign lp_o      = wait_i || stop_i;
    assign wakeup_o  = stop_i && irq_i;
endmodule

// File: rtl/periodic_tick_irq.sv
module periodic_tick_irq
    import tbi_pkg::*;
#(
    parameter int unsigned CNT_W      = 22,
    parameter int unsigned PSCL_SHIFT = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic [REG_W-1:0] bus_wdata,
    output logic [REG_W-1:0] bus_rdata,
    input  logic             wait_mode,
    input  logic             stop_mode,
    input  logic             stop_clk_en,
    output logic             irq,
    output logic             wakeup
);
    logic              run, ie, pscl, flag, tick, adv, lp;
    logic [RATE_W-1:0] rate;

    tbi_regs u_regs (
        .clk(clk), .rst_n(rst_n),
        .sel_i(bus_sel), .wr_i(bus_wr), .wdata_i(bus_wdata),
        .lp_i(lp), .tick_i(tick), .rdata_o(bus_rdata),
        .run_o(run), .ie_o(ie), .rate_o(rate), .pscl_o(pscl), .flag_o(flag)
    );

    tbi_counter #(.CNT_W(CNT_W), .PSCL_SHIFT(PSCL_SHIFT)) u_cnt (
        .clk(clk), .rst_n(rst_n), .run_i(run), .adv_i(adv),
        .rate_i(rate), .pscl_i(pscl), .tick_o(tick)
    );

    tbi_lowpower u_lp (
        .run_i(run), .wait_i(wait_mode), .stop_i(stop_mode),
        .stop_clk_en_i(stop_clk_en), .irq_i(irq),
        .adv_o(adv), .lp_o(lp), .wakeup_o(wakeup)
    );

    assign irq = flag && ie;

    assert_wake_in_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        wakeup |-> (stop_mode && irq));

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(run) || $past(flag));

endmodule

// File: tb/test_periodic_tick_irq.sv
module test_periodic_tick_irq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       wait_mode = 1'b0, stop_mode = 1'b0, stop_clk_en = 1'b0;
    logic       irq, wakeup;

    int checks = 0;
    int fails  = 0;

    localparam logic [7:0] ACK = 8'h40;

    // {prescale, rate code, expected period}
    localparam int unsigned VEC[12][3] = '{
        '{0, 7, 8},     '{0, 6, 16},    '{0, 5, 32},    '{0, 4, 64},
        '{0, 3, 128},   '{0, 2, 2048},  '{0, 1, 8192},  '{0, 0, 32768},
        '{1, 7, 1024},  '{1, 6, 2048},  '{1, 5, 4096},  '{1, 4, 8192}
    };

    periodic_tick_irq i_periodic_tick_irq (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .wait_mode(wait_mode), .stop_mode(stop_mode), .stop_clk_en(stop_clk_en),
        .irq(irq), .wakeup(wakeup)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] cfg(input bit p, input int unsigned r, input bit ie, input bit run);
        return {2'b00, p, r[2:0], ie, run};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic restart(input logic [7:0] d);
        bus_write(ACK);
        bus_write(d);
    endtask

    task automatic wait_irq(output int n, input int limit);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!irq && n <= limit);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
    end

    initial begin
        int n;
        int first;
        logic [7:0] rd;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 rdata", bus_rdata, 0);
        chk("R1 irq", irq, 0);
        chk("R1 wakeup", wakeup, 0);

        // period table, R2 (prescale 0) and R3 (prescale 1)
        foreach (VEC[i]) begin
            restart(cfg(VEC[i][0][0], VEC[i][1], 1, 1));
            wait_irq(n, VEC[i][2] + 4);
            chk(VEC[i][0] ? "R3 period" : "R2 period", n, VEC[i][2]);
        end

        // R5 rate lock while running
        restart(cfg(0, 7, 0, 1));
        bus_write(cfg(1, 0, 0, 1));
        rd = bus_rdata;
        chk("R5 rate kept", rd[4:2], 7);
        chk("R5 prescale kept", rd[5], 0);

        // R6 sticky flag and acknowledge, R11 free-running repeat
        restart(cfg(0, 7, 0, 1));
        for (int k = 1; k <= 16; k++) begin
            @(negedge clk);
            if (k == 8) begin
                chk("R6 flag set", bus_rdata[7], 1);
                chk("R6 irq masked", irq, 0);
                bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = ACK | cfg(0, 7, 0, 1);
            end
            if (k == 9) begin
                bus_sel = 1'b0; bus_wr = 1'b0;
                chk("R6 flag cleared", bus_rdata[7], 0);
            end
            if (k == 15) chk("R11 no early flag", bus_rdata[7], 0);
            if (k == 16) chk("R11 second period", bus_rdata[7], 1);
        end
        bus_write(cfg(0, 7, 1, 1));
        chk("R6 irq enabled", irq, 1);

        // R7 acknowledge coinciding with period end
        restart(cfg(0, 7, 0, 1));
        for (int k = 1; k <= 17; k++) begin
            @(negedge clk);
            if (k == 15 || k == 16) begin
                if (k == 16) chk("R7 flag survives", bus_rdata[7], 1);
                bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = ACK | cfg(0, 7, 0, 1);
            end
            if (k == 17) begin
                bus_sel = 1'b0; bus_wr = 1'b0;
                chk("R7 later ack clears", bus_rdata[7], 0);
            end
        end

        // R4 disable holds counter at zero
        restart(cfg(0, 7, 1, 1));
        repeat (5) @(negedge clk);
        bus_write(cfg(0, 7, 1, 0));
        first = 0;
        repeat (30) begin
            @(negedge clk);
            if (irq) first = 1;
        end
        chk("R4 no flag while disabled", first, 0);
        bus_write(cfg(0, 7, 1, 1));
        wait_irq(n, 20);
        chk("R4 exact restart", n, 8);

        // R8 wait mode: counting continues, bus locked out
        restart(cfg(0, 7, 1, 1));
        for (int k = 1; k <= 8; k++) begin
            @(negedge clk);
            if (k == 1) begin
                wait_mode = 1'b1;
                bus_sel = 1'b1; bus_wr = 1'b1; bus_wdata = ACK;
                #1 chk("R8 read zero", bus_rdata, 0);
            end
            if (k == 2) begin bus_sel = 1'b0; bus_wr = 1'b0; end
            if (k == 7) chk("R8 no early irq", irq, 0);
            if (k == 8) chk("R8 irq in wait", irq, 1);
        end
        wait_mode = 1'b0;
        #1 chk("R8 register intact", bus_rdata, 8'h9F);

        // R9 stop without clock freezes the count
        restart(cfg(0, 7, 1, 1));
        first = 0;
        for (int k = 1; k <= 40; k++) begin
            @(negedge clk);
            if (irq && first == 0) first = k;
            if (k == 2) begin stop_mode = 1'b1; stop_clk_en = 1'b0; end
            if (k == 5) #1 chk("R8 read zero in stop", bus_rdata, 0);
            if (k == 22) stop_mode = 1'b0;
        end
        chk("R9 stretched period", first, 28);

        // R10 stop with clock: wakeup
        restart(cfg(0, 7, 1, 1));
        for (int k = 1; k <= 9; k++) begin
            @(negedge clk);
            if (k == 2) begin stop_mode = 1'b1; stop_clk_en = 1'b1; end
            if (k == 7) chk("R10 no early wakeup", wakeup, 0);
            if (k == 8) chk("R10 wakeup", wakeup, 1);
            if (k == 9) begin
                stop_mode = 1'b0;
                #1 chk("R10 wakeup only in stop", wakeup, 0);
                chk("R10 irq still pending", irq, 1);
            end
        end
        stop_clk_en = 1'b0;

        summary();
    end
endmodule